// File: doc/BRIEF.md
# Cascadable Three-Wire Serial Code Loader

This block is the digital front end of a 16-bit converter. A host drives three wires: a serial clock, a data line and a load strobe. On each rising serial clock edge one data bit enters a shift register, most significant bit first. A rising edge on the load strobe copies the shift register into a held code register, and that register feeds the converter. The held code changes only on a load strobe. Shifting alone never changes it.

The bit that leaves the far end of the shift register is driven onto a serial output on each falling serial clock edge. While a new word is shifted in, the serial output therefore carries the word that was in the register before. Feeding one unit's serial output into the next unit's data input builds a chain of any length. A single common load strobe then updates every unit at once.

The three serial wires are asynchronous to the system clock. They are brought into the system clock domain by a synchroniser, and edges are found in that domain. A clear input acts asynchronously and forces the held code to the bottom of the span, code 0x0000. The power-up reset does the same. A two-bit range select is reported back as the active span.

There is no stream handshake. The serial link has no back-pressure, so the host paces the bits and keeps each serial clock phase longer than the synchroniser latency. The held code is a level output with no valid strobe.

Top module: `serial_dac_loader`

## Requirements
- R1: After 16 rising serial clock edges and then a load strobe, `code` equals the shifted word. The first bit shifted becomes bit 15.
- R2: Each bit is the level of `sdi` at the rising serial clock edge. Changes on `sdi` while `sclk` is high have no effect on the stored word.
- R3: `code` changes only after a rising edge of `latch`. Shifting a whole word without a load strobe leaves `code` unchanged.
- R4: While a word is shifted in, `sdo` presents the previous shift register contents, most significant bit first. `sdo` changes only after a falling serial clock edge.
- R5: A high `clr` forces `code` to 0x0000 at once, without waiting for a clock edge. `code` stays at 0x0000 while `clr` is high, and a load strobe during that time is ignored. The shift register is not affected, so the first load strobe after `clr` is released loads the word that was shifted before.
- R6: After reset, `code` is 0x0000 and `sdo` is 0.
- R7: One system clock after `range_sel` is applied, `span` equals it. The encodings are 00 for the 0–5 V span, 01 for 4–20 mA, 10 for 0–20 mA and 11 for 0–24 mA. `span_is_volt` is 1 only for 00.
- R8: A load strobe does not clear the shift register. A second load strobe with no shifting in between loads the same code again, and the next word shifted out on `sdo` is still the last word shifted in.
- R9: In a chain of two units with a shared clock and strobe, the far unit's held code is the word shifted one word earlier than the near unit's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| clr | input | 1 | Asynchronous clear of the held code, active high |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data in |
| latch | input | 1 | Load strobe, acts on its rising edge |
| range_sel | input | 2 | Requested span |
| code | output | WORD_W | Held converter code |
| sdo | output | 1 | Serial data out, for cascading |
| span | output | 2 | Span in use |
| span_is_volt | output | 1 | High when the voltage span is selected |

## Verification
Directed words cover the edge values: 0xFFFF, 0x0000, a single set MSB and a single set LSB. These expose a swapped bit order or an off-by-one shift. A run of random words with random load strobes and random clear pulses separates the shift path from the held path, because code and shift register must then diverge. The data line is flipped while the serial clock is high, so a design that samples late is caught. The serial output is compared bit by bit with the previous word, and a second unit is cascaded behind the first, so the one-word delay of the chain is measured directly. A load strobe issued while clear is high, followed by a load strobe after release, shows that clear wins and that the shift register is left intact.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int DL_WORD_W = 16;

  typedef enum logic [1:0] {
    SPAN_V0_5  = 2'b00,
    SPAN_I4_20 = 2'b01,
    SPAN_I0_20 = 2'b10,
    SPAN_I0_24 = 2'b11
  } span_e;

  function automatic logic span_is_voltage(span_e s);
    return s == SPAN_V0_5;
  endfunction
endpackage

// File: rtl/dl_sync.sv
module dl_sync #(
  parameter int N     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      logic [DEPTH-1:0] pipe;
      if (DEPTH == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe <= '0;
          else        pipe <= din[g];
        end
      end else begin : g_many
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe <= '0;
          else        pipe <= {pipe[DEPTH-2:0], din[g]};
        end
      end
      assign lvl[g] = pipe[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dl_shift_chain.sv
module dl_shift_chain #(
  parameter int W = dl_pkg::DL_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         out_en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         sdo
);
  logic [W-1:0] sreg;
  logic         sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sdo_q <= 1'b0;
    else if (out_en) sdo_q <= sreg[W-1];
  end

  assign word = sreg;
  assign sdo  = sdo_q;

  p_shift_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sreg[W-1:1] == $past(sreg[W-2:0]));

  p_idle_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg));

  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(sdo_q));
endmodule

// File: rtl/dl_hold_reg.sv
module dl_hold_reg #(
  parameter int W = dl_pkg::DL_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] BOTTOM = '0;

  logic arst_n;
  assign arst_n = rst_n & ~clr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q <= BOTTOM;
    else if (load) q <= d;
  end

  p_clear_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> q == BOTTOM);

  p_hold_without_load_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !load |=> $stable(q));

  p_load_copies_r1: assert property (@(posedge clk) disable iff (!rst_n || clr)
    load |=> q == $past(d));
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader #(
  parameter int WORD_W     = dl_pkg::DL_WORD_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              latch,
  input  logic [1:0]        range_sel,
  output logic [WORD_W-1:0] code,
  output logic              sdo,
  output logic [1:0]        span,
  output logic              span_is_volt
);
  import dl_pkg::*;

  localparam int NSYNC  = 3;
  localparam int I_SCLK = 0;
  localparam int I_SDI  = 1;
  localparam int I_LAT  = 2;

  logic [NSYNC-1:0] raw_in, syn;
  logic [1:0]       prev;
  logic             sclk_rise, sclk_fall, lat_rise;
  logic [WORD_W-1:0] sh_word;
  span_e            span_q;
  logic             volt_q;

  assign raw_in = {latch, sdi, sclk};

  dl_sync #(.N(NSYNC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .lvl(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= {syn[I_LAT], syn[I_SCLK]};
  end

  assign sclk_rise = syn[I_SCLK] & ~prev[0];
  assign sclk_fall = ~syn[I_SCLK] & prev[0];
  assign lat_rise  = syn[I_LAT] & ~prev[1];

  dl_shift_chain #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .out_en(sclk_fall),
    .din(syn[I_SDI]), .word(sh_word), .sdo(sdo)
  );

  dl_hold_reg #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(lat_rise),
    .d(sh_word), .q(code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= SPAN_V0_5;
      volt_q <= 1'b1;
    end else begin
      span_q <= span_e'(range_sel);
      volt_q <= span_is_voltage(span_e'(range_sel));
    end
  end

  assign span         = span_q;
  assign span_is_volt = volt_q;

  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);

  p_strobe_keeps_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !sclk_rise) |=> $stable(sh_word));

  p_span_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> span == $past(range_sel));

  p_volt_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    span_is_volt == (span == 2'b00));
endmodule

// File: tb/test_serial_dac_loader.sv
module test_serial_dac_loader;
  logic clk = 0;
  logic rst_n = 0, clr = 0, sclk = 0, sdi = 0, latch = 0;
  logic [1:0] range_sel = 2'b00;
  logic [15:0] code0, code1;
  logic sdo0, sdo1, volt0, volt1;
  logic [1:0] span0, span1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m0 = 0, m1 = 0, c0 = 0, c1 = 0;

  always #10 clk = ~clk;

  serial_dac_loader i_serial_dac_loader (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sclk(sclk), .sdi(sdi), .latch(latch),
    .range_sel(range_sel), .code(code0), .sdo(sdo0), .span(span0), .span_is_volt(volt0)
  );

  serial_dac_loader i_serial_dac_loader_tail (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sclk(sclk), .sdi(sdo0), .latch(latch),
    .range_sel(range_sel), .code(code1), .sdo(sdo1), .span(span1), .span_is_volt(volt1)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(logic [15:0] w);
    logic [15:0] seen0, seen1;
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      tick(4);
      seen0[i] = sdo0;
      seen1[i] = sdo1;
      sclk = 1;
      tick(3);
      sdi = 1'($urandom_range(0, 1));   // R2: late change must be ignored
      tick(5);
      sclk = 0;
      tick(8);
    end
    chk("R4 near sdo", {16'h0, seen0}, {16'h0, m0});
    chk("R4 tail sdo", {16'h0, seen1}, {16'h0, m1});
    m1 = m0;
    m0 = w;
  endtask

  task automatic strobe();
    latch = 1;
    tick(8);
    latch = 0;
    tick(8);
    if (!clr) begin
      c0 = m0;
      c1 = m1;
    end
  endtask

  task automatic check_codes(string tag);
    chk(tag, {16'h0, code0}, {16'h0, c0});
    chk({tag, " tail R9"}, {16'h0, code1}, {16'h0, c1});
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(5);
    rst_n = 1;
    tick(5);
    chk("R6 code", {16'h0, code0}, 0);
    chk("R6 sdo", {31'h0, sdo0}, 0);

    for (int r = 0; r < 4; r++) begin
      range_sel = 2'(r);
      tick(2);
      chk("R7 span", {30'h0, span0}, r);
      chk("R7 volt", {31'h0, volt0}, (r == 0) ? 1 : 0);
    end

    shift_word(16'hA5C3);
    check_codes("R3 no strobe");
    strobe();
    check_codes("R1 first word");
    strobe();
    check_codes("R8 repeat strobe");
    shift_word(16'h1234);             // R8: sdo must still carry A5C3
    strobe();
    check_codes("R9 chain");

    clr = 1;
    #2;
    chk("R5 async clear", {16'h0, code0}, 0);
    chk("R5 async clear tail", {16'h0, code1}, 0);
    c0 = 0;
    c1 = 0;
    tick(2);
    strobe();
    check_codes("R5 strobe under clear");
    clr = 0;
    tick(2);
    check_codes("R5 after release");
    strobe();
    c0 = m0;
    c1 = m1;
    check_codes("R5 shift reg kept");

    shift_word(16'hFFFF);
    shift_word(16'h0000);
    strobe();
    check_codes("R1 all zero");
    shift_word(16'h8000);
    strobe();
    check_codes("R1 msb only");
    shift_word(16'h0001);
    strobe();
    check_codes("R1 lsb only");

    for (int k = 0; k < 24; k++) begin
      logic [15:0] w;
      w = 16'($urandom());
      range_sel = 2'($urandom_range(0, 3));
      shift_word(w);
      chk("R7 span rnd", {30'h0, span0}, {30'h0, range_sel});
      if ($urandom_range(0, 1) == 1) strobe();
      check_codes("R3 random");
      if ($urandom_range(0, 4) == 0) begin
        clr = 1;
        tick(3);
        clr = 0;
        tick(3);
        c0 = 0;
        c1 = 0;
        check_codes("R5 random clear");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule